// File: doc/BRIEF.md
# Serial Port Control Register with Synchronized Enables

This block is the control word of a serial port. It sits in the bus clock domain and holds the framing options (character size, stop bits, parity type, infrared encoding, start-of-frame detection, collision detection). Those options drive the datapath directly. It also holds two request fields, the receiver/transmitter enables and the FIFO clear. Changes to these must reach a separate core clock domain. A third request field, a line-header command, is a write-only strobe.

Requests travel through a busy handshake. The bus side flips a request toggle, which crosses into the core domain through a flip-flop chain. The core sees the requested values on `core_req_*` and confirms them with `core_ack`. An acknowledge toggle then crosses back, and the busy flag drops. While the flag is up, any write to the register is refused with a bus error. An enable that is being switched on reads as 0 until the core has confirmed it. When the port-level enable is low, enable writes take effect at once, with no handshake. When the port-level enable rises, the stored enables are sent to the core.

Top module: `sercfg_ctrl`

## Requirements
- R1: After reset the register reads 0x00000000, `sync_busy` is 0 and all core-side outputs are 0.
- R2: Odd parity (bit 13), infrared encoding (bit 10), start-of-frame detect (bit 9), collision detect (bit 8), two stop bits (bit 6) and character size (bits 2:0) are stored by any accepted write. They read back at those positions and drive the `cfg_*` outputs from the next clock on, without raising `sync_busy`.
- R3: Bits 25:24 are a line-header command strobe. They always read 0. An accepted write drives `lin_cmd_pulse` with the written code for exactly one cycle after the write, and with 0 otherwise.
- R4: With `port_en` low, a write to receiver enable (bit 17) or transmitter enable (bit 16) that leaves bits 23:22 at 0 reads back from the next cycle, and `sync_busy` stays 0.
- R5: With `port_en` high, a write that turns an enable from 0 to 1 raises `sync_busy` and the bit reads 0 while busy. `core_req` then shows the requested enables. After `core_ack`, `sync_busy` falls, the bit reads 1 and `core_rx_en`/`core_tx_en` follow the request.
- R6: A write while `sync_busy` is 1 raises `bus_err` in that cycle and changes no stored field.
- R7: FIFO clear (bits 23:22; 1 = TX, 2 = RX, 3 = both) is always synchronized. The written code reads back while busy and appears on `core_req_fifo_clr`. From the clock after `sync_busy` falls the field reads 0.
- R8: With `port_en` high, a write that keeps both enables and writes FIFO clear 0 does not raise `sync_busy`.
- R9: A rise of `port_en` sends the stored enables to the core. The enable bits keep reading their stored values during that transfer.
- R10: `core_ack` while `core_req` is 0 is ignored. The core enables stay unchanged and `sync_busy` stays 0.
- R11: With `port_en` high, writing 0 to a set enable reads 0 from the next cycle and starts a transfer. The matching core enable drops after `core_ack`.
- R12: Writes to any other address change nothing and raise no `bus_err`. Reads of other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst_n | input | 1 | Bus-side asynchronous reset, active low |
| core_clk | input | 1 | Core-side clock |
| core_rst_n | input | 1 | Core-side asynchronous reset, active low |
| port_en | input | 1 | Port-level enable; selects immediate or synchronized enable writes |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| bus_err | output | 1 | Error response: write refused while busy |
| sync_busy | output | 1 | Cross-domain transfer in progress |
| lin_cmd_pulse | output | 2 | One-cycle line-header command strobe |
| cfg_parity_odd | output | 1 | Odd parity selected |
| cfg_irda | output | 1 | Infrared encoding selected |
| cfg_sof_det | output | 1 | Start-of-frame detection enabled |
| cfg_coll_det | output | 1 | Collision detection enabled |
| cfg_two_stop | output | 1 | Two stop bits selected |
| cfg_char_size | output | 3 | Character size code |
| core_req | output | 1 | Core-side request pending |
| core_req_rx_en | output | 1 | Requested receiver enable |
| core_req_tx_en | output | 1 | Requested transmitter enable |
| core_req_fifo_clr | output | 2 | Requested FIFO clear code, 0 when no request |
| core_ack | input | 1 | Core confirms the pending request |
| core_rx_en | output | 1 | Receiver enable applied in the core domain |
| core_tx_en | output | 1 | Transmitter enable applied in the core domain |

## Verification
The hardest situation to reach is a write that lands while a transfer is still in flight. The window is held open by the bench, which withholds `core_ack`. It fires a refused write at that point, and then confirms that neither the readback nor the later transfer shows any trace of that write. The port-enable rise is placed after immediate writes, so the queued transfer carries enables that were never handshaked. Random framing words and stray addresses are mixed in with `port_en` high, so that the no-busy path is tested beside the synchronized one.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
   localparam int DATA_W   = 32;
   localparam int LIN_LSB  = 24;
   localparam int CLR_LSB  = 22;
   localparam int RXEN_BIT = 17;
   localparam int TXEN_BIT = 16;
   localparam int PAR_BIT  = 13;
   localparam int ENC_BIT  = 10;
   localparam int SOF_BIT  = 9;
   localparam int COL_BIT  = 8;
   localparam int STOP_BIT = 6;
   localparam int CSZ_LSB  = 0;
   localparam int CSZ_W    = 3;

   typedef struct packed {
      logic             parity_odd;
      logic             irda;
      logic             sof_det;
      logic             coll_det;
      logic             two_stop;
      logic [CSZ_W-1:0] char_size;
   } static_cfg_t;

   typedef struct packed {
      logic       rx_en;
      logic       tx_en;
      logic [1:0] fifo_clr;
   } sync_cfg_t;
endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sercfg_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      logic [W-1:0] r;
      logic [W-1:0] src;
      if (i == 0) begin : g_first
         assign src = d;
      end else begin : g_next
         assign src = g_stg[i-1].r;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= '0;
         else        r <= src;
      end
   end

   assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/sercfg_bus_regs.sv
module sercfg_bus_regs
   import sercfg_pkg::*;
#(
   parameter int              ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   input  logic              ack_tgl_s,
   output logic              req_tgl,
   output sync_cfg_t         sync_val,
   output static_cfg_t       static_cfg,
   output logic [1:0]        lin_pulse,
   output logic              busy
);
   logic        sel, wr_ok, en_chg, wr_launch, idle_launch, launch, en_rise;
   logic        port_en_q, launch_pend;
   logic        rx_q, tx_q;
   logic [1:0]  clr_q, newen_q, lin_q;
   static_cfg_t st_q, w_st;
   logic        w_rx, w_tx;
   logic [1:0]  w_clr, w_lin;

   assign sel     = (bus_addr == REG_ADDR);
   assign busy    = req_tgl ^ ack_tgl_s;
   assign wr_ok   = sel & bus_wr & ~busy;
   assign bus_err = sel & bus_wr & busy;

   assign w_rx  = bus_wdata[RXEN_BIT];
   assign w_tx  = bus_wdata[TXEN_BIT];
   assign w_clr = bus_wdata[CLR_LSB +: 2];
   assign w_lin = bus_wdata[LIN_LSB +: 2];
   assign w_st  = '{parity_odd: bus_wdata[PAR_BIT], irda: bus_wdata[ENC_BIT],
                    sof_det: bus_wdata[SOF_BIT], coll_det: bus_wdata[COL_BIT],
                    two_stop: bus_wdata[STOP_BIT],
                    char_size: bus_wdata[CSZ_LSB +: CSZ_W]};

   assign en_rise     = port_en & ~port_en_q;
   assign en_chg      = port_en & ((w_rx != rx_q) | (w_tx != tx_q));
   assign wr_launch   = wr_ok & (en_chg | (w_clr != 2'b00) | launch_pend);
   assign idle_launch = ~busy & ~wr_ok & launch_pend;
   assign launch      = wr_launch | idle_launch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_en_q   <= 1'b0;
         launch_pend <= 1'b0;
         req_tgl     <= 1'b0;
         lin_q       <= 2'b00;
         st_q        <= '0;
         rx_q        <= 1'b0;
         tx_q        <= 1'b0;
         clr_q       <= 2'b00;
         newen_q     <= 2'b00;
      end else begin
         port_en_q   <= port_en;
         launch_pend <= en_rise | (launch_pend & ~launch);
         req_tgl     <= req_tgl ^ launch;
         lin_q       <= wr_ok ? w_lin : 2'b00;
         if (wr_ok) begin
            st_q    <= w_st;
            rx_q    <= w_rx;
            tx_q    <= w_tx;
            clr_q   <= w_clr;
            newen_q <= port_en ? {w_rx & ~rx_q, w_tx & ~tx_q} : 2'b00;
         end else if (!busy) begin
            clr_q   <= 2'b00;
            newen_q <= 2'b00;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (sel) begin
         bus_rdata[CLR_LSB +: 2]       = clr_q;
         bus_rdata[RXEN_BIT]           = rx_q & ~(newen_q[1] & busy);
         bus_rdata[TXEN_BIT]           = tx_q & ~(newen_q[0] & busy);
         bus_rdata[PAR_BIT]            = st_q.parity_odd;
         bus_rdata[ENC_BIT]            = st_q.irda;
         bus_rdata[SOF_BIT]            = st_q.sof_det;
         bus_rdata[COL_BIT]            = st_q.coll_det;
         bus_rdata[STOP_BIT]           = st_q.two_stop;
         bus_rdata[CSZ_LSB +: CSZ_W]   = st_q.char_size;
      end
   end

   assign sync_val   = '{rx_en: rx_q, tx_en: tx_q, fifo_clr: clr_q};
   assign static_cfg = st_q;
   assign lin_pulse  = lin_q;

   // R6: a refused write leaves every stored field untouched
   p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |=> $stable({st_q, rx_q, tx_q, clr_q}));

   // R5: values seen by the core domain hold still for the whole transfer
   p_cross_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable({rx_q, tx_q, clr_q}));

   // R4: immediate enable path never starts a handshake
   p_immediate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !port_en && w_clr == 2'b00 && !launch_pend) |=> !busy);

   // R7: the clear code is gone one clock after the handshake ends
   p_clr_selfclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !bus_wr) |=> (clr_q == 2'b00));
endmodule

// File: rtl/sercfg_core_side.sv
module sercfg_core_side
   import sercfg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_tgl_s,
   input  sync_cfg_t sync_val,
   input  logic      core_ack,
   output logic      ack_tgl,
   output logic      core_req,
   output sync_cfg_t core_req_val,
   output logic      core_rx_en,
   output logic      core_tx_en
);
   logic      seen_q, req_q, new_req, take;
   sync_cfg_t pend_q;

   assign new_req = req_tgl_s ^ seen_q;
   assign take    = req_q & core_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q     <= 1'b0;
         req_q      <= 1'b0;
         pend_q     <= '0;
         ack_tgl    <= 1'b0;
         core_rx_en <= 1'b0;
         core_tx_en <= 1'b0;
      end else begin
         if (new_req) begin
            seen_q <= req_tgl_s;
            pend_q <= sync_val;
            req_q  <= 1'b1;
         end else if (take) begin
            req_q      <= 1'b0;
            ack_tgl    <= ~ack_tgl;
            core_rx_en <= pend_q.rx_en;
            core_tx_en <= pend_q.tx_en;
         end
      end
   end

   assign core_req     = req_q;
   assign core_req_val = '{rx_en: pend_q.rx_en, tx_en: pend_q.tx_en,
                           fifo_clr: req_q ? pend_q.fifo_clr : 2'b00};

   // R5: a new request never arrives on top of an unconfirmed one
   p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      new_req |-> !req_q);

   // R10: applied enables move only on a confirmed request
   p_apply_on_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ({core_rx_en, core_tx_en} != $past({core_rx_en, core_tx_en}))
         |-> $past(core_ack && req_q));
endmodule

// File: rtl/sercfg_ctrl.sv
module sercfg_ctrl
   import sercfg_pkg::*;
#(
   parameter int                ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR    = 'h04,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              core_clk,
   input  logic              core_rst_n,
   input  logic              port_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_err,
   output logic              sync_busy,
   output logic [1:0]        lin_cmd_pulse,
   output logic              cfg_parity_odd,
   output logic              cfg_irda,
   output logic              cfg_sof_det,
   output logic              cfg_coll_det,
   output logic              cfg_two_stop,
   output logic [2:0]        cfg_char_size,
   output logic              core_req,
   output logic              core_req_rx_en,
   output logic              core_req_tx_en,
   output logic [1:0]        core_req_fifo_clr,
   input  logic              core_ack,
   output logic              core_rx_en,
   output logic              core_tx_en
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sercfg_ctrl: SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("sercfg_ctrl: ADDR_W out of range");
   end

   logic        req_tgl, req_tgl_s, ack_tgl, ack_tgl_s;
   sync_cfg_t   sync_val, core_val;
   static_cfg_t st;

   sercfg_bus_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_bus (
      .clk(bus_clk), .rst_n(bus_rst_n), .port_en(port_en),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err), .ack_tgl_s(ack_tgl_s),
      .req_tgl(req_tgl), .sync_val(sync_val), .static_cfg(st),
      .lin_pulse(lin_cmd_pulse), .busy(sync_busy));

   sercfg_sync #(.STAGES(SYNC_STAGES), .W(1)) u_req_sync (
      .clk(core_clk), .rst_n(core_rst_n), .d(req_tgl), .q(req_tgl_s));

   sercfg_sync #(.STAGES(SYNC_STAGES), .W(1)) u_ack_sync (
      .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_tgl_s));

   sercfg_core_side u_core (
      .clk(core_clk), .rst_n(core_rst_n), .req_tgl_s(req_tgl_s),
      .sync_val(sync_val), .core_ack(core_ack), .ack_tgl(ack_tgl),
      .core_req(core_req), .core_req_val(core_val),
      .core_rx_en(core_rx_en), .core_tx_en(core_tx_en));

   assign cfg_parity_odd    = st.parity_odd;
   assign cfg_irda          = st.irda;
   assign cfg_sof_det       = st.sof_det;
   assign cfg_coll_det      = st.coll_det;
   assign cfg_two_stop      = st.two_stop;
   assign cfg_char_size     = st.char_size;
   assign core_req_rx_en    = core_val.rx_en;
   assign core_req_tx_en    = core_val.tx_en;
   assign core_req_fifo_clr = core_val.fifo_clr;
endmodule

// File: tb/sercfg_ctrl_tb.sv
module sercfg_ctrl_tb;
   localparam logic [7:0]  RA   = 8'h04;
   localparam logic [31:0] SMSK = 32'h0000_2747;

   logic bus_clk = 0, core_clk = 0, bus_rst_n = 0, core_rst_n = 0;
   logic port_en = 0, bus_wr = 0, core_ack = 0;
   logic [7:0]  bus_addr = RA;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic bus_err, sync_busy, cfg_parity_odd, cfg_irda, cfg_sof_det, cfg_coll_det, cfg_two_stop;
   logic [1:0] lin_cmd_pulse, core_req_fifo_clr;
   logic [2:0] cfg_char_size;
   logic core_req, core_req_rx_en, core_req_tx_en, core_rx_en, core_tx_en;

   int n_tests = 0, n_fail = 0;

   always #10 bus_clk  = ~bus_clk;
   always #13 core_clk = ~core_clk;

   sercfg_ctrl u_dut (.*);

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] word(input logic [31:0] st, input logic rx, input logic tx,
                                        input logic [1:0] clr, input logic [1:0] lin);
      return (st & SMSK) | (32'(rx) << 17) | (32'(tx) << 16) | (32'(clr) << 22) | (32'(lin) << 24);
   endfunction

   function automatic logic [31:0] cfg_out_word();
      return word({18'b0, cfg_parity_odd, 2'b0, cfg_irda, cfg_sof_det, cfg_coll_det, 1'b0,
                   cfg_two_stop, 3'b0, cfg_char_size}, 1'b0, 1'b0, 2'b00, 2'b00);
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic err);
      @(negedge bus_clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1;
      #1 err = bus_err;
      @(negedge bus_clk);
      bus_wr = 0; bus_addr = RA;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
      bus_addr = RA;
   endtask

   task automatic wait_busy(input logic v, output logic ok);
      ok = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge bus_clk);
         if (sync_busy == v) begin ok = 1; break; end
      end
   endtask

   task automatic wait_req(output logic ok);
      ok = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge core_clk);
         if (core_req) begin ok = 1; break; end
      end
   endtask

   task automatic pulse_ack();
      @(negedge core_clk); core_ack = 1;
      @(negedge core_clk); core_ack = 0;
   endtask

   initial begin
      #4_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic err, ok;
      logic [31:0] r, st, w;
      logic rx, tx;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge bus_clk);
      bus_rst_n = 1; core_rst_n = 1;
      @(negedge bus_clk);

      // R1 reset state
      rd(RA, r); chk("R1", "rdata", r, 32'h0);
      chk("R1", "busy", 32'(sync_busy), 0);
      chk("R1", "core", {core_req, core_rx_en, core_tx_en, core_req_fifo_clr}, 0);

      // R2 static fields with port disabled, random words
      rx = 0; tx = 0; st = 0;
      for (int i = 0; i < 8; i++) begin
         st = $urandom() & SMSK;
         wr(RA, word(st, 0, 0, 0, 0), err);
         chk("R2", "no err", 32'(err), 0);
         rd(RA, r); chk("R2", "readback", r, st);
         chk("R2", "cfg outputs", cfg_out_word(), st);
         chk("R2", "no busy", 32'(sync_busy), 0);
      end

      // R3 line-header strobe
      wr(RA, word(st, 0, 0, 0, 2'd2), err);
      chk("R3", "pulse", 32'(lin_cmd_pulse), 2);
      rd(RA, r); chk("R3", "reads zero", r & 32'h0300_0000, 0);
      @(negedge bus_clk);
      chk("R3", "pulse gone", 32'(lin_cmd_pulse), 0);

      // R4 immediate enable while port disabled
      wr(RA, word(st, 1, 0, 0, 0), err);
      rx = 1;
      rd(RA, r); chk("R4", "rx reads 1", r, word(st, rx, tx, 0, 0));
      chk("R4", "no busy", 32'(sync_busy), 0);

      // R10 stray acknowledge
      pulse_ack();
      repeat (4) @(negedge bus_clk);
      chk("R10", "core en unchanged", {core_rx_en, core_tx_en}, 0);
      chk("R10", "no busy", 32'(sync_busy), 0);

      // R9 port enable rise sends stored enables
      @(negedge bus_clk); port_en = 1;
      wait_busy(1, ok); chk("R9", "busy rose", 32'(ok), 1);
      rd(RA, r); chk("R9", "rx still reads 1", r, word(st, rx, tx, 0, 0));
      wait_req(ok); chk("R9", "core_req", 32'(ok), 1);
      chk("R9", "req values", {core_req_rx_en, core_req_tx_en}, 2'b10);
      pulse_ack();
      wait_busy(0, ok); chk("R9", "busy fell", 32'(ok), 1);
      chk("R9", "core rx on", {core_rx_en, core_tx_en}, 2'b10);

      // R5 synchronized enable of the transmitter
      wr(RA, word(st, 1, 1, 0, 0), err);
      tx = 1;
      chk("R5", "busy", 32'(sync_busy), 1);
      rd(RA, r); chk("R5", "tx reads 0 while busy", r, word(st, 1, 0, 0, 0));
      wait_req(ok); chk("R5", "core_req", 32'(ok), 1);
      chk("R5", "req values", {core_req_rx_en, core_req_tx_en}, 2'b11);

      // R6 write refused while busy
      w = word(~st, 0, 0, 2'd3, 0);
      wr(RA, w, err);
      chk("R6", "bus_err", 32'(err), 1);
      rd(RA, r); chk("R6", "unchanged", r, word(st, 1, 0, 0, 0));
      chk("R6", "cfg unchanged", cfg_out_word(), st);

      pulse_ack();
      wait_busy(0, ok); chk("R5", "busy fell", 32'(ok), 1);
      @(negedge bus_clk);
      rd(RA, r); chk("R5", "tx reads 1", r, word(st, 1, 1, 0, 0));
      chk("R5", "core enables", {core_rx_en, core_tx_en}, 2'b11);

      // R7 FIFO clear both
      wr(RA, word(st, 1, 1, 2'd3, 0), err);
      rd(RA, r); chk("R7", "clr reads back", r, word(st, 1, 1, 2'd3, 0));
      wait_req(ok); chk("R7", "clr on core", 32'(core_req_fifo_clr), 3);
      pulse_ack();
      wait_busy(0, ok); @(negedge bus_clk);
      rd(RA, r); chk("R7", "clr self-cleared", r, word(st, 1, 1, 0, 0));
      chk("R7", "core clr idle", 32'(core_req_fifo_clr), 0);

      // R11 disable receiver while port enabled
      wr(RA, word(st, 0, 1, 0, 0), err);
      rx = 0;
      rd(RA, r); chk("R11", "rx reads 0", r, word(st, 0, 1, 0, 0));
      chk("R11", "busy", 32'(sync_busy), 1);
      wait_req(ok); chk("R11", "req rx 0", {core_req_rx_en, core_req_tx_en}, 2'b01);
      pulse_ack();
      wait_busy(0, ok); chk("R11", "busy fell", 32'(ok), 1);
      chk("R11", "core rx off", {core_rx_en, core_tx_en}, 2'b01);

      // R8 / R12 random framing writes and stray addresses with port enabled
      for (int i = 0; i < 24; i++) begin
         logic [7:0] a;
         w = $urandom();
         a = ($urandom() % 4 == 0) ? 8'($urandom()) | 8'h80 : RA;
         wr(a, word(w, rx, tx, 0, 0), err);
         if (a == RA) begin
            st = w & SMSK;
            chk("R8", "no err", 32'(err), 0);
            chk("R8", "no busy", 32'(sync_busy), 0);
            rd(RA, r); chk("R8", "readback", r, word(st, rx, tx, 0, 0));
         end else begin
            chk("R12", "no err", 32'(err), 0);
            rd(RA, r); chk("R12", "reg unchanged", r, word(st, rx, tx, 0, 0));
            rd(a, r); chk("R12", "other reads 0", r, 0);
         end
         chk("R8", "cfg outputs", cfg_out_word(), st);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule